// File: doc/BRIEF.md
# T1 Receive Data Link Extractor

This block sits behind a T1 receive framer that already knows where each frame and multiframe begins. It follows the framed bit stream one line bit at a time, finds the overhead bits that carry the data link for the chosen framing format, and sends them to a selected destination. The overhead port gives external equipment a data output and a strobe that pulses only at data-link bit positions.

The framer feeds the block from a fast system clock. It asserts `bit_en` once for each line bit, every `OVS` clocks. It flags the F-bit of every frame with `fbit_mark` and flags the first frame of the multiframe with `mf_mark`. A 2-bit destination select sends the extracted bits to one of three places: a message-controller interface, the overhead port, or the serial output only. A fourth setting overwrites them with ones in the serial output.

Top module: `t1dl_extractor`

## Requirements
- R1: Frames are counted from 1, and the frame flagged by `mf_mark` together with `fbit_mark` is frame 1. The data-link bit positions depend on `fmt_sel`. With 2'b00 (extended superframe) they are the F-bit of odd frames. With 2'b01 (SLC96) and 2'b10 (N) they are the F-bit of even frames. With 2'b11 (T1DM) they are bit 191 of every frame, which is the seventh bit of timeslot 24, counting the F-bit as bit 0.
- R2: When `dest_sel` is 2'b10, `oh_clk` rises exactly once for each data-link bit, on the clock edge at which that bit is presented with `bit_en`. It rises at no other time.
- R3: Each `oh_clk` pulse stays high for exactly `OVS/2` clocks, which is half a line bit period.
- R4: `oh_data` takes the data-link bit on the same edge at which `oh_clk` rises. It holds that value through the falling edge and until the next rise.
- R5: While `dest_sel` is not 2'b10, from the next clock on `oh_clk` is low and `oh_data` is 1.
- R6: When `dest_sel` is 2'b00, each data-link bit produces one `msg_valid` pulse one clock long, with `msg_data` equal to the bit. With any other select value `msg_valid` stays low.
- R7: On every `bit_en` edge, `ser_data` registers the incoming bit and holds it until the next `bit_en`. When `dest_sel` is 2'b11, data-link positions are replaced by 1. With the other select values those positions pass unchanged.
- R8: A synchronous active-high `rst` drives `oh_clk` and `msg_valid` low and drives `oh_data` and `ser_data` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `OVS` cycles per line bit |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies one line bit on this clock |
| rx_data | input | 1 | Received line bit |
| fbit_mark | input | 1 | Current bit is the frame's F-bit |
| mf_mark | input | 1 | With `fbit_mark`: first frame of the multiframe |
| fmt_sel | input | 2 | Framing format (see R1) |
| dest_sel | input | 2 | Data-link destination (see R2, R5 to R7) |
| oh_clk | output | 1 | Overhead port strobe |
| oh_data | output | 1 | Overhead port data |
| ser_data | output | 1 | Receive serial data, one bit delayed |
| msg_valid | output | 1 | Message-controller bit valid |
| msg_data | output | 1 | Message-controller bit |

## Verification
The internal state is a bit position counter, a frame counter and a pulse-width counter, and each fault shows at the ports within one line bit. A bit or frame counter that drifts moves the `oh_clk` edge to the wrong bit. The data captured then belongs to a different bit, and the number of strobes per multiframe is wrong. A pulse counter that is off by one makes the strobe longer or shorter than half a bit, which shows on the next falling edge. A select decode fault shows within one data-link bit: a strobe fires where none belongs, a message pulse goes missing, or a forced one is missing from `ser_data`.

// File: rtl/t1dl_pkg.sv
package t1dl_pkg;
   typedef enum logic [1:0] {
      FMT_ESF  = 2'b00,
      FMT_SLC  = 2'b01,
      FMT_NSF  = 2'b10,
      FMT_T1DM = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      DST_MSG  = 2'b00,
      DST_SER  = 2'b01,
      DST_OHP  = 2'b10,
      DST_ONES = 2'b11
   } dst_e;
endpackage

// File: rtl/t1dl_locator.sv
module t1dl_locator
   import t1dl_pkg::*;
#(
   parameter int FRAME_BITS = 193,
   parameter int MF_FRAMES  = 24,
   parameter int RB_SLOT    = 24,
   parameter int RB_INDEX   = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic fbit_mark,
   input  logic mf_mark,
   input  fmt_e fmt,
   output logic dl_hit
);
   localparam int POS_W = $clog2(FRAME_BITS);
   localparam int FRM_W = $clog2(MF_FRAMES + 1);
   localparam int RPOS  = 1 + (RB_SLOT - 1) * 8 + RB_INDEX;

   if (RPOS >= FRAME_BITS) begin : g_bad_rpos
      $error("R-bit position lies outside the frame");
   end

   logic [POS_W-1:0] pos_q, pos_d;
   logic [FRM_W-1:0] frm_q, frm_d;

   always_comb begin
      pos_d = fbit_mark ? '0 : pos_q + POS_W'(1);
      if (fbit_mark && mf_mark)
         frm_d = FRM_W'(1);
      else if (fbit_mark)
         frm_d = frm_q + FRM_W'(1);
      else
         frm_d = frm_q;
   end

   always_comb begin
      unique case (fmt)
         FMT_ESF:          dl_hit = fbit_mark && frm_d[0];
         FMT_SLC, FMT_NSF: dl_hit = fbit_mark && !frm_d[0] && (frm_d != '0);
         default:          dl_hit = !fbit_mark && (pos_d == POS_W'(RPOS));
      endcase
      dl_hit = dl_hit && bit_en;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= '0;
         frm_q <= '0;
      end else if (bit_en) begin
         pos_q <= pos_d;
         frm_q <= frm_d;
      end
   end
endmodule

// File: rtl/t1dl_router.sv
module t1dl_router
   import t1dl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic dl_hit,
   input  logic rx_data,
   input  dst_e dst,
   output logic ser_data,
   output logic msg_valid,
   output logic msg_data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ser_data  <= 1'b1;
         msg_valid <= 1'b0;
         msg_data  <= 1'b0;
      end else begin
         if (bit_en)
            ser_data <= (dl_hit && dst == DST_ONES) ? 1'b1 : rx_data;
         msg_valid <= dl_hit && dst == DST_MSG;
         msg_data  <= (dl_hit && dst == DST_MSG) ? rx_data : 1'b0;
      end
   end
endmodule

// File: rtl/t1dl_strobe.sv
module t1dl_strobe #(
   parameter int OVS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic enable,
   input  logic fire,
   input  logic din,
   output logic strb,
   output logic dout
);
   localparam int HALF = OVS / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (rst || !enable) begin
            strb <= 1'b0;
            dout <= 1'b1;
         end else begin
            strb <= fire;
            if (fire) dout <= din;
         end
      end
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst || !enable) begin
            strb <= 1'b0;
            dout <= 1'b1;
            cnt  <= '0;
         end else if (fire) begin
            strb <= 1'b1;
            dout <= din;
            cnt  <= CW'(HALF - 1);
         end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
         end else begin
            strb <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/t1dl_extractor.sv
module t1dl_extractor
   import t1dl_pkg::*;
#(
   parameter int OVS        = 4,
   parameter int FRAME_BITS = 193,
   parameter int MF_FRAMES  = 24,
   parameter int RB_SLOT    = 24,
   parameter int RB_INDEX   = 6
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bit_en,
   input  logic       rx_data,
   input  logic       fbit_mark,
   input  logic       mf_mark,
   input  logic [1:0] fmt_sel,
   input  logic [1:0] dest_sel,
   output logic       oh_clk,
   output logic       oh_data,
   output logic       ser_data,
   output logic       msg_valid,
   output logic       msg_data
);
   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 2");
   end
   if (MF_FRAMES < 2 || RB_SLOT < 1 || RB_INDEX > 7) begin : g_bad_geom
      $error("frame geometry parameters out of range");
   end

   fmt_e fmt;
   dst_e dst;
   logic dl_hit;

   assign fmt = fmt_e'(fmt_sel);
   assign dst = dst_e'(dest_sel);

   t1dl_locator #(
      .FRAME_BITS(FRAME_BITS),
      .MF_FRAMES (MF_FRAMES),
      .RB_SLOT   (RB_SLOT),
      .RB_INDEX  (RB_INDEX)
   ) u_loc (
      .clk      (clk),
      .rst      (rst),
      .bit_en   (bit_en),
      .fbit_mark(fbit_mark),
      .mf_mark  (mf_mark),
      .fmt      (fmt),
      .dl_hit   (dl_hit)
   );

   t1dl_router u_rte (
      .clk      (clk),
      .rst      (rst),
      .bit_en   (bit_en),
      .dl_hit   (dl_hit),
      .rx_data  (rx_data),
      .dst      (dst),
      .ser_data (ser_data),
      .msg_valid(msg_valid),
      .msg_data (msg_data)
   );

   t1dl_strobe #(.OVS(OVS)) u_stb (
      .clk   (clk),
      .rst   (rst),
      .enable(dst == DST_OHP),
      .fire  (dl_hit && dst == DST_OHP),
      .din   (rx_data),
      .strb  (oh_clk),
      .dout  (oh_data)
   );
endmodule

// File: rtl/t1dl_checker.sv
module t1dl_checker #(
   parameter int OVS = 4
) (
   input logic       clk,
   input logic       rst,
   input logic       bit_en,
   input logic [1:0] dest_sel,
   input logic       oh_clk,
   input logic       oh_data,
   input logic       ser_data,
   input logic       msg_valid
);
   localparam int HALF = OVS / 2;
   localparam int CW   = $clog2(OVS + 2);

   logic [CW-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (rst)         hi_cnt <= '0;
      else if (oh_clk) hi_cnt <= hi_cnt + CW'(1);
      else             hi_cnt <= '0;
   end

   a_r2_rise_on_bit: assert property (@(posedge clk) disable iff (rst)
      $rose(oh_clk) |-> $past(bit_en) && $past(dest_sel) == 2'b10);

   a_r3_no_long_pulse: assert property (@(posedge clk) disable iff (rst)
      oh_clk |-> hi_cnt < CW'(HALF));

   a_r3_full_pulse: assert property (@(posedge clk) disable iff (rst)
      ($fell(oh_clk) && !$past(rst) && $past(dest_sel) == 2'b10)
      |-> $past(hi_cnt) == CW'(HALF - 1));

   a_r4_hold_data: assert property (@(posedge clk) disable iff (rst)
      ($past(oh_clk) && !$past(rst) && $past(dest_sel) == 2'b10)
      |-> $stable(oh_data));

   a_r5_idle_port: assert property (@(posedge clk) disable iff (rst)
      (dest_sel != 2'b10) |=> (!oh_clk && oh_data));

   a_r6_msg_dest: assert property (@(posedge clk) disable iff (rst)
      msg_valid |-> $past(dest_sel) == 2'b00 && $past(bit_en));

   a_r8_reset_state: assert property (@(posedge clk)
      rst |=> (!oh_clk && oh_data && ser_data && !msg_valid));
endmodule

bind t1dl_extractor t1dl_checker #(.OVS(OVS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bit_en   (bit_en),
   .dest_sel (dest_sel),
   .oh_clk   (oh_clk),
   .oh_data  (oh_data),
   .ser_data (ser_data),
   .msg_valid(msg_valid)
);

// File: tb/t1dl_extractor_bench.sv
module t1dl_extractor_bench;
   localparam int OVS = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_en = 1'b0, rx_data = 1'b0, fbit_mark = 1'b0, mf_mark = 1'b0;
   logic [1:0] fmt_sel = 2'b00, dest_sel = 2'b10;
   logic       oh_clk, oh_data, ser_data, msg_valid, msg_data;

   int n_cmp = 0, n_bad = 0, n_rise = 0, hi = 0;
   bit oh_prev = 1'b0, last_d = 1'b0;
   bit exp_q[$];
   bit msg_q[$];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   t1dl_extractor #(.OVS(OVS)) u_t1dl_extractor (
      .clk(clk), .rst(rst), .bit_en(bit_en), .rx_data(rx_data),
      .fbit_mark(fbit_mark), .mf_mark(mf_mark), .fmt_sel(fmt_sel),
      .dest_sel(dest_sel), .oh_clk(oh_clk), .oh_data(oh_data),
      .ser_data(ser_data), .msg_valid(msg_valid), .msg_data(msg_data)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit is_dl(int fmt, int fr, int pos);
      case (fmt)
         0:       return pos == 0 && (fr % 2) == 1;
         1, 2:    return pos == 0 && (fr % 2) == 0;
         default: return pos == 191;
      endcase
   endfunction

   task automatic send_bit(bit f, bit m, bit d, bit dl);
      @(negedge clk);
      bit_en = 1'b1; fbit_mark = f; mf_mark = m; rx_data = d;
      if (dl && dest_sel == 2'b10) exp_q.push_back(d);
      if (dl && dest_sel == 2'b00) msg_q.push_back(d);
      @(negedge clk);
      bit_en = 1'b0; fbit_mark = 1'b0; mf_mark = 1'b0;
      // R7: serial output, forced ones at data-link positions for select 11
      chk(ser_data === ((dl && dest_sel == 2'b11) ? 1'b1 : d),
          dl ? "R7 ser_data at data-link bit" : "R7 ser_data pass",
          int'(ser_data), int'((dl && dest_sel == 2'b11) ? 1'b1 : d));
      repeat (OVS - 2) @(negedge clk);
   endtask

   task automatic run(int fmt, int dest, int nfr);
      int exp_rise;
      fmt_sel = 2'(fmt); dest_sel = 2'(dest); n_rise = 0;
      for (int fr = 1; fr <= nfr; fr++) begin
         for (int pos = 0; pos < 193; pos++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(pos == 0, pos == 0 && fr == 1, lfsr[0], is_dl(fmt, fr, pos));
         end
      end
      repeat (4) @(negedge clk);
      // R1: strobe count per run follows from the format's positions
      exp_rise = (dest != 2) ? 0 : (fmt == 3) ? nfr : nfr / 2;
      chk(n_rise == exp_rise, "R1 strobe count", n_rise, exp_rise);
      chk(exp_q.size() == 0, "R2 missing strobes", exp_q.size(), 0);
      chk(msg_q.size() == 0, "R6 missing message bits", msg_q.size(), 0);
      if (dest != 2) begin
         // R5: idle overhead port
         chk(oh_clk === 1'b0, "R5 oh_clk idle", int'(oh_clk), 0);
         chk(oh_data === 1'b1, "R5 oh_data idle", int'(oh_data), 1);
      end
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         if (!rst) begin
            if (oh_clk && !oh_prev) begin
               n_rise++;
               hi = 1;
               last_d = oh_data;
               if (exp_q.size() == 0)
                  chk(1'b0, "R2 unexpected oh_clk rise", 1, 0);
               else begin
                  bit e;
                  e = exp_q.pop_front();
                  chk(oh_data === e, "R4 oh_data at rise", int'(oh_data), int'(e));
               end
            end else if (oh_clk) begin
               hi++;
            end else if (oh_prev) begin
               chk(hi == OVS / 2, "R3 strobe width", hi, OVS / 2);
               chk(oh_data === last_d, "R4 oh_data across fall", int'(oh_data), int'(last_d));
            end
            if (msg_valid) begin
               if (msg_q.size() == 0)
                  chk(1'b0, "R6 unexpected msg_valid", 1, 0);
               else begin
                  bit e;
                  e = msg_q.pop_front();
                  chk(msg_data === e, "R6 msg_data", int'(msg_data), int'(e));
               end
            end
         end
         oh_prev = oh_clk;
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(oh_clk === 1'b0, "R8 reset oh_clk", int'(oh_clk), 0);
      chk(oh_data === 1'b1, "R8 reset oh_data", int'(oh_data), 1);
      chk(ser_data === 1'b1, "R8 reset ser_data", int'(ser_data), 1);
      chk(msg_valid === 1'b0, "R8 reset msg_valid", int'(msg_valid), 0);
      rst = 1'b0;
      run(0, 2, 24);   // R1 ESF to overhead port
      run(1, 2, 24);   // R1 SLC96
      run(2, 2, 12);   // R1 N format
      run(3, 2, 12);   // R1 T1DM R bit
      run(0, 0, 12);   // R6 message path
      run(0, 1, 12);   // R5 serial only
      run(0, 3, 12);   // R7 forced ones
      run(3, 3, 4);    // R7 forced ones at R-bit
      run(3, 2, 2);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      // R8: reset after traffic
      chk(oh_clk === 1'b0, "R8 reset oh_clk after traffic", int'(oh_clk), 0);
      chk(oh_data === 1'b1, "R8 reset oh_data after traffic", int'(oh_data), 1);
      chk(ser_data === 1'b1, "R8 reset ser_data after traffic", int'(ser_data), 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule